// File: doc/BRIEF.md
# Tag Rule Cache with Miss Trap

This block checks tag policy for every instruction of a tagged stack processor. When the sequencer dispatches a user-mode instruction, it supplies the opcode, the tag of the program counter and the operand tags. The block turns these into a five-field lookup key and compares the key with the one rule instance it holds. On a hit, the block returns in the same cycle the new PC tag and the result tag. The datapath merges these with its normal result.

On a miss, the block copies the key into its input fields and saves a return frame holding the PC and the privilege bit. It then raises a one-cycle trap so the sequencer branches to the handler entry in kernel mode. In kernel mode the cache is bypassed. The handler reads and writes the seven rule cells through a small word port. It then either issues a privileged return, which restores the PC so the faulting instruction retries, or jumps to the all-ones address, which halts the block for good.

Tags follow a two-point encoding: 0 is the lowest label, 1 is the highest label, and all-ones is the default tag. The default tag is used for operand positions an opcode does not consume and for values the kernel produces.

Top module: `tag_rule_cache`

## Requirements
- R1: After reset the block is in user mode, not halted, with trap and resume pulses low. Cell 0 (opcode) reads 0 and cells 1 to 6 read all-ones. The outputs are marked invalid, so no lookup hits until both output cells have been written.
- R2: Operand tags at positions not below `usrArgCnt` (0 to 3 operands, tag 1 first) are replaced by the all-ones default tag. This applies both when comparing and when capturing a key, so a key matches exactly on all five input fields: opcode (cell 0), PC tag (cell 1), operand tags 1 to 3 (cells 2 to 4).
- R3: A user-mode `usrValid` whose masked key equals cells 0 to 4, while the outputs are valid, raises `ruleHit` in the same cycle. On that hit, `ruleResTag` equals cell 5 and `rulePcTag` equals cell 6, and no trap follows.
- R4: A user-mode `usrValid` that does not hit produces the following one cycle later. `trapPulse` is high for exactly one cycle, `kernelMode` is 1, and cells 0 to 4 hold the masked key. `trapTarget` carries the handler entry address.
- R5: In kernel mode, `usrValid` never raises `ruleHit`, never traps and never alters the cells.
- R6: The port addresses cells 0 to 6. Reads are combinational at any time. A write with `kWrEn` takes effect at the next edge only in kernel mode. In user mode, writes are ignored.
- R7: A kernel write to any of cells 0 to 4, or a miss capture, invalidates the outputs. They become valid again only after both cell 5 and cell 6 have been written.
- R8: `retStrobe` in kernel mode restores the saved privilege bit (user mode) on the next cycle. It also pulses `resumeValid` for one cycle, with `resumePc` equal to the PC of the faulting instruction. The retried instruction then hits with the tags the handler wrote.
- R9: A kernel `kJump` to the all-ones address sets `halted`, which stays set until reset. While halted, there are no hits, traps, returns or cell writes. A kernel jump to any other address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usrValid | input | 1 | Instruction dispatch strobe |
| usrOpcode | input | OP_W | Opcode of the dispatched instruction |
| usrArgCnt | input | 2 | Number of operand tags the opcode consumes |
| usrPcTag | input | TAG_W | Current PC tag |
| usrTag1 | input | TAG_W | First operand tag |
| usrTag2 | input | TAG_W | Second operand tag |
| usrTag3 | input | TAG_W | Third operand tag |
| usrPc | input | PC_W | PC of the dispatched instruction |
| ruleHit | output | 1 | Cached rule matched this dispatch |
| rulePcTag | output | TAG_W | New PC tag from the cache |
| ruleResTag | output | TAG_W | Result tag from the cache |
| trapPulse | output | 1 | One-cycle trap request after a miss |
| trapTarget | output | PC_W | Handler entry address |
| kernelMode | output | 1 | Privilege bit, 1 in kernel mode |
| kAddr | input | 3 | Cell address for the kernel port |
| kWrEn | input | 1 | Kernel cell write strobe |
| kWrData | input | TAG_W | Kernel cell write data |
| kRdData | output | TAG_W | Cell read data |
| retStrobe | input | 1 | Privileged return |
| kJump | input | 1 | Kernel jump strobe |
| kJumpAddr | input | PC_W | Kernel jump target |
| resumeValid | output | 1 | One-cycle pulse when returning to the saved PC |
| resumePc | output | PC_W | Saved PC of the faulting instruction |
| halted | output | 1 | Sticky halt after a denied operation |

## Verification
The bench builds the block with 8-bit tags, a 5-bit opcode and a 12-bit PC, with the handler entry at 0x100. With these widths, the two-point labels 0 and 1, the all-ones default 0xFF, and operand garbage values that differ from the default can all appear side by side. The small PC width gives an all-ones halt address that is easy to tell apart from ordinary jump targets. A table of dispatches covers both outcomes of each lookup: hits that arise only after operand masking, and misses that go through capture, handler fill, return and retry.

// File: rtl/tag_rule_pkg.sv
package tag_rule_pkg;
  localparam int NUM_CELLS = 7;
  localparam int NUM_KEY   = 5;
  localparam int NUM_ARGS  = 3;
  localparam int CELL_OP    = 0;
  localparam int CELL_PCTAG = 1;
  localparam int CELL_ARG0  = 2;
  localparam int CELL_RES   = 5;
  localparam int CELL_NEWPC = 6;

  typedef struct packed {
    logic capture;  // copy masked key and return frame
    logic wrEn;     // kernel write accepted this cycle
  } ctlStrobes_t;
endpackage

// File: rtl/tag_rule_dp.sv
module tag_rule_dp
  import tag_rule_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int OP_W  = 5,
  parameter int PC_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [OP_W-1:0]   usrOpcode,
  input  logic [1:0]        usrArgCnt,
  input  logic [TAG_W-1:0]  usrPcTag,
  input  logic [TAG_W-1:0]  usrTag1,
  input  logic [TAG_W-1:0]  usrTag2,
  input  logic [TAG_W-1:0]  usrTag3,
  input  logic [PC_W-1:0]   usrPc,
  input  logic              kernelMode,
  input  logic [2:0]        kAddr,
  input  logic [TAG_W-1:0]  kWrData,
  output logic              keyMatch,
  output logic [TAG_W-1:0]  rulePcTag,
  output logic [TAG_W-1:0]  ruleResTag,
  output logic [TAG_W-1:0]  kRdData,
  output logic [PC_W-1:0]   savedPc,
  output logic              savedPriv
);
  localparam logic [TAG_W-1:0] DEFAULT_TAG = {TAG_W{1'b1}};

  logic [TAG_W-1:0] cellQ  [NUM_CELLS];
  logic [TAG_W-1:0] keyVec [NUM_KEY];
  logic [TAG_W-1:0] argRaw [NUM_ARGS];

  assign argRaw[0] = usrTag1;
  assign argRaw[1] = usrTag2;
  assign argRaw[2] = usrTag3;

  assign keyVec[CELL_OP]    = TAG_W'(usrOpcode);
  assign keyVec[CELL_PCTAG] = usrPcTag;

  // unused operand positions take the default tag
  for (genvar g = 0; g < NUM_ARGS; g++) begin : gArgMask
    assign keyVec[CELL_ARG0+g] = (usrArgCnt > 2'(g)) ? argRaw[g] : DEFAULT_TAG;
  end

  always_comb begin
    keyMatch = 1'b1;
    for (int i = 0; i < NUM_KEY; i++) begin
      if (keyVec[i] != cellQ[i]) keyMatch = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CELLS; i++) begin
        cellQ[i] <= (i == CELL_OP) ? '0 : DEFAULT_TAG;
      end
    end else begin
      for (int i = 0; i < NUM_CELLS; i++) begin
        if (strb.capture && i < NUM_KEY) begin
          cellQ[i] <= keyVec[i];
        end else if (strb.wrEn && kAddr == 3'(i)) begin
          cellQ[i] <= kWrData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPc   <= '0;
      savedPriv <= 1'b0;
    end else if (strb.capture) begin
      savedPc   <= usrPc;
      savedPriv <= kernelMode;
    end
  end

  always_comb begin
    kRdData = '0;
    for (int i = 0; i < NUM_CELLS; i++) begin
      if (kAddr == 3'(i)) kRdData = cellQ[i];
    end
  end

  assign ruleResTag = cellQ[CELL_RES];
  assign rulePcTag  = cellQ[CELL_NEWPC];
endmodule

// File: rtl/tag_rule_ctl.sv
module tag_rule_ctl
  import tag_rule_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            usrValid,
  input  logic            keyMatch,
  input  logic [2:0]      kAddr,
  input  logic            kWrEn,
  input  logic            retStrobe,
  input  logic            kJump,
  input  logic [PC_W-1:0] kJumpAddr,
  input  logic            savedPriv,
  output ctlStrobes_t     strb,
  output logic            ruleHit,
  output logic            kernelMode,
  output logic            trapPulse,
  output logic            resumeValid,
  output logic            halted
);
  localparam logic [PC_W-1:0] HALT_ADDR = {PC_W{1'b1}};

  logic kernelQ, haltQ, trapQ, resumeQ, resWrQ, pcWrQ;
  logic lookupEn, outValid, miss, kWrOk, denyJump, retOk, keyFieldWr;

  assign outValid   = resWrQ & pcWrQ;
  assign lookupEn   = usrValid & ~kernelQ & ~haltQ;
  assign ruleHit    = lookupEn & outValid & keyMatch;
  assign miss       = lookupEn & ~ruleHit;
  assign kWrOk      = kWrEn & kernelQ & ~haltQ & (kAddr < 3'(NUM_CELLS));
  assign keyFieldWr = kWrOk & (kAddr < 3'(NUM_KEY));
  assign denyJump   = kJump & kernelQ & ~haltQ & (kJumpAddr == HALT_ADDR);
  assign retOk      = retStrobe & kernelQ & ~haltQ & ~denyJump;

  assign strb.capture = miss;
  assign strb.wrEn    = kWrOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kernelQ <= 1'b0;
      haltQ   <= 1'b0;
      trapQ   <= 1'b0;
      resumeQ <= 1'b0;
    end else begin
      trapQ   <= miss;
      resumeQ <= retOk;
      if (denyJump) haltQ <= 1'b1;
      if (miss) kernelQ <= 1'b1;
      else if (retOk) kernelQ <= savedPriv;
    end
  end

  // output validity: both output cells must be written after any key change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resWrQ <= 1'b0;
      pcWrQ  <= 1'b0;
    end else if (miss || keyFieldWr) begin
      resWrQ <= 1'b0;
      pcWrQ  <= 1'b0;
    end else if (kWrOk) begin
      if (kAddr == 3'(CELL_RES))   resWrQ <= 1'b1;
      if (kAddr == 3'(CELL_NEWPC)) pcWrQ  <= 1'b1;
    end
  end

  assign kernelMode  = kernelQ;
  assign trapPulse   = trapQ;
  assign resumeValid = resumeQ;
  assign halted      = haltQ;
endmodule

// File: rtl/tag_rule_cache.sv
module tag_rule_cache
  import tag_rule_pkg::*;
#(
  parameter int              TAG_W      = 8,
  parameter int              OP_W       = 5,
  parameter int              PC_W       = 12,
  parameter logic [PC_W-1:0] HANDLER_PC = 12'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usrValid,
  input  logic [OP_W-1:0]   usrOpcode,
  input  logic [1:0]        usrArgCnt,
  input  logic [TAG_W-1:0]  usrPcTag,
  input  logic [TAG_W-1:0]  usrTag1,
  input  logic [TAG_W-1:0]  usrTag2,
  input  logic [TAG_W-1:0]  usrTag3,
  input  logic [PC_W-1:0]   usrPc,
  output logic              ruleHit,
  output logic [TAG_W-1:0]  rulePcTag,
  output logic [TAG_W-1:0]  ruleResTag,
  output logic              trapPulse,
  output logic [PC_W-1:0]   trapTarget,
  output logic              kernelMode,
  input  logic [2:0]        kAddr,
  input  logic              kWrEn,
  input  logic [TAG_W-1:0]  kWrData,
  output logic [TAG_W-1:0]  kRdData,
  input  logic              retStrobe,
  input  logic              kJump,
  input  logic [PC_W-1:0]   kJumpAddr,
  output logic              resumeValid,
  output logic [PC_W-1:0]   resumePc,
  output logic              halted
);
  ctlStrobes_t strb;
  logic        keyMatch;
  logic        savedPriv;

  tag_rule_ctl #(.PC_W(PC_W)) uCtl (
    .clk(clk), .rstN(rstN), .usrValid(usrValid), .keyMatch(keyMatch),
    .kAddr(kAddr), .kWrEn(kWrEn), .retStrobe(retStrobe), .kJump(kJump),
    .kJumpAddr(kJumpAddr), .savedPriv(savedPriv), .strb(strb),
    .ruleHit(ruleHit), .kernelMode(kernelMode), .trapPulse(trapPulse),
    .resumeValid(resumeValid), .halted(halted)
  );

  tag_rule_dp #(.TAG_W(TAG_W), .OP_W(OP_W), .PC_W(PC_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .usrOpcode(usrOpcode),
    .usrArgCnt(usrArgCnt), .usrPcTag(usrPcTag), .usrTag1(usrTag1),
    .usrTag2(usrTag2), .usrTag3(usrTag3), .usrPc(usrPc),
    .kernelMode(kernelMode), .kAddr(kAddr), .kWrData(kWrData),
    .keyMatch(keyMatch), .rulePcTag(rulePcTag), .ruleResTag(ruleResTag),
    .kRdData(kRdData), .savedPc(resumePc), .savedPriv(savedPriv)
  );

  assign trapTarget = HANDLER_PC;
endmodule

// File: rtl/tag_rule_cache_chk.sv
module tag_rule_cache_chk (
  input logic clk,
  input logic rstN,
  input logic usrValid,
  input logic ruleHit,
  input logic trapPulse,
  input logic kernelMode,
  input logic resumeValid,
  input logic retStrobe,
  input logic halted
);
  p_trap_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |=> !trapPulse);
  p_trap_kernel_r4: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> kernelMode);
  p_trap_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> $past(usrValid && !kernelMode && !halted && !ruleHit));
  p_no_hit_kernel_r5: assert property (@(posedge clk) disable iff (!rstN)
    kernelMode |-> !ruleHit);
  p_resume_user_r8: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |-> !kernelMode);
  p_resume_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |-> $past(retStrobe && kernelMode && !halted));
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!ruleHit && !trapPulse));
endmodule

bind tag_rule_cache tag_rule_cache_chk uChk (
  .clk(clk), .rstN(rstN), .usrValid(usrValid), .ruleHit(ruleHit),
  .trapPulse(trapPulse), .kernelMode(kernelMode), .resumeValid(resumeValid),
  .retStrobe(retStrobe), .halted(halted)
);

// File: tb/tag_rule_cache_test.sv
module tag_rule_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 8;
  localparam int OP_W  = 5;
  localparam int PC_W  = 12;
  localparam logic [PC_W-1:0] HANDLER_PC = 12'h100;
  localparam logic [TAG_W-1:0] DEF = 8'hFF;

  typedef struct packed {
    logic [1:0] cnt;
    logic [4:0] op;
    logic [11:0] pc;
    logic [7:0] pcTag, t1, t2, t3, res, npc;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 5'd3, 12'h010, 8'h00, 8'h00, 8'h01, 8'h55, 8'h01, 8'h00},
    '{2'd2, 5'd3, 12'h011, 8'h00, 8'h00, 8'h01, 8'h22, 8'h00, 8'h01},
    '{2'd2, 5'd3, 12'h012, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00},
    '{2'd1, 5'd7, 12'h020, 8'h01, 8'h00, 8'h33, 8'h44, 8'h01, 8'h01},
    '{2'd1, 5'd7, 12'h021, 8'h01, 8'h00, 8'h99, 8'h00, 8'h00, 8'h00},
    '{2'd0, 5'd2, 12'h030, 8'h00, 8'h05, 8'h06, 8'h07, 8'hFF, 8'h00},
    '{2'd3, 5'd2, 12'h031, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00},
    '{2'd3, 5'd2, 12'h032, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h01}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usrValid = 1'b0;
  logic [OP_W-1:0] usrOpcode = '0;
  logic [1:0] usrArgCnt = '0;
  logic [TAG_W-1:0] usrPcTag = '0, usrTag1 = '0, usrTag2 = '0, usrTag3 = '0;
  logic [PC_W-1:0] usrPc = '0;
  logic ruleHit, trapPulse, kernelMode, resumeValid, halted;
  logic [TAG_W-1:0] rulePcTag, ruleResTag, kRdData;
  logic [PC_W-1:0] trapTarget, resumePc;
  logic [2:0] kAddr = '0;
  logic kWrEn = 1'b0;
  logic [TAG_W-1:0] kWrData = '0;
  logic retStrobe = 1'b0;
  logic kJump = 1'b0;
  logic [PC_W-1:0] kJumpAddr = '0;

  int nTests = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic [TAG_W-1:0] mKey [5];
  logic mValid = 1'b0;
  logic [TAG_W-1:0] mRes, mPc;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_rule_cache #(.TAG_W(TAG_W), .OP_W(OP_W), .PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) uut (
    .clk(clk), .rstN(rstN), .usrValid(usrValid), .usrOpcode(usrOpcode),
    .usrArgCnt(usrArgCnt), .usrPcTag(usrPcTag), .usrTag1(usrTag1),
    .usrTag2(usrTag2), .usrTag3(usrTag3), .usrPc(usrPc), .ruleHit(ruleHit),
    .rulePcTag(rulePcTag), .ruleResTag(ruleResTag), .trapPulse(trapPulse),
    .trapTarget(trapTarget), .kernelMode(kernelMode), .kAddr(kAddr),
    .kWrEn(kWrEn), .kWrData(kWrData), .kRdData(kRdData), .retStrobe(retStrobe),
    .kJump(kJump), .kJumpAddr(kJumpAddr), .resumeValid(resumeValid),
    .resumePc(resumePc), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input vec_t v);
    usrValid = 1'b1; usrOpcode = v.op; usrArgCnt = v.cnt; usrPcTag = v.pcTag;
    usrTag1 = v.t1; usrTag2 = v.t2; usrTag3 = v.t3; usrPc = v.pc;
    #1;
  endtask

  task automatic kWrite(input logic [2:0] a, input logic [TAG_W-1:0] d);
    kWrEn = 1'b1; kAddr = a; kWrData = d;
    tick();
    kWrEn = 1'b0;
  endtask

  task automatic kRead(input logic [2:0] a, output logic [TAG_W-1:0] d);
    kAddr = a;
    #1;
    d = kRdData;
  endtask

  task automatic doReturn(input logic [PC_W-1:0] expPc, input string req);
    retStrobe = 1'b1;
    tick();
    retStrobe = 1'b0;
    chk(resumeValid == 1'b1, req, "resume pulse", resumeValid, 1);
    chk(resumePc == expPc, req, "resume pc", resumePc, expPc);
    chk(kernelMode == 1'b0, req, "back to user", kernelMode, 0);
    tick();
    chk(resumeValid == 1'b0, req, "resume single", resumeValid, 0);
  endtask

  function automatic logic [TAG_W-1:0] maskArg(input logic [1:0] cnt, input int idx,
                                               input logic [TAG_W-1:0] t);
    return (int'(cnt) > idx) ? t : DEF;
  endfunction

  task automatic runVec(input vec_t v, input int n);
    logic [TAG_W-1:0] k [5];
    logic [TAG_W-1:0] rd;
    bit expHit;
    k[0] = TAG_W'(v.op); k[1] = v.pcTag;
    k[2] = maskArg(v.cnt, 0, v.t1);
    k[3] = maskArg(v.cnt, 1, v.t2);
    k[4] = maskArg(v.cnt, 2, v.t3);
    expHit = mValid;
    for (int i = 0; i < 5; i++) if (k[i] != mKey[i]) expHit = 1'b0;
    drive(v);
    // R2 R3: masked key decides the hit
    chk(ruleHit == expHit, "R3", $sformatf("vec%0d hit", n), ruleHit, expHit);
    if (expHit) begin
      chk(ruleResTag == mRes, "R3", "result tag", ruleResTag, mRes);
      chk(rulePcTag == mPc, "R3", "pc tag", rulePcTag, mPc);
    end
    tick();
    usrValid = 1'b0;
    if (expHit) begin
      chk(trapPulse == 1'b0, "R3", "no trap on hit", trapPulse, 0);
    end else begin
      chk(trapPulse == 1'b1, "R4", "trap", trapPulse, 1);
      chk(kernelMode == 1'b1, "R4", "kernel", kernelMode, 1);
      chk(trapTarget == HANDLER_PC, "R4", "target", trapTarget, HANDLER_PC);
      for (int i = 0; i < 5; i++) begin
        kRead(3'(i), rd);
        chk(rd == k[i], "R2", $sformatf("captured cell %0d", i), rd, k[i]);
      end
      kWrite(3'd5, v.res);
      kWrite(3'd6, v.npc);
      doReturn(v.pc, "R8");
      drive(v);
      chk(ruleHit == 1'b1, "R8", "retry hit", ruleHit, 1);
      chk(ruleResTag == v.res, "R8", "retry result", ruleResTag, v.res);
      chk(rulePcTag == v.npc, "R8", "retry pc tag", rulePcTag, v.npc);
      tick();
      usrValid = 1'b0;
      for (int i = 0; i < 5; i++) mKey[i] = k[i];
      mValid = 1'b1; mRes = v.res; mPc = v.npc;
    end
  endtask

  task automatic checkReset();
    logic [TAG_W-1:0] rd;
    chk(kernelMode == 1'b0, "R1", "user mode", kernelMode, 0);
    chk(halted == 1'b0, "R1", "not halted", halted, 0);
    chk(trapPulse == 1'b0, "R1", "no trap", trapPulse, 0);
    chk(resumeValid == 1'b0, "R1", "no resume", resumeValid, 0);
    kRead(3'd0, rd); chk(rd == 8'h00, "R1", "cell0", rd, 0);
    kRead(3'd1, rd); chk(rd == DEF, "R1", "cell1", rd, DEF);
    kRead(3'd5, rd); chk(rd == DEF, "R1", "cell5", rd, DEF);
    kRead(3'd6, rd); chk(rd == DEF, "R1", "cell6", rd, DEF);
    // key equal to the reset cells must still miss: outputs invalid
    drive('{2'd0, 5'd0, 12'h001, DEF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    chk(ruleHit == 1'b0, "R1", "no hit after reset", ruleHit, 0);
    usrValid = 1'b0;
    #1;
  endtask

  initial begin
    logic [TAG_W-1:0] rd;
    vec_t kv;
    for (int i = 0; i < 5; i++) mKey[i] = '0;
    mRes = '0; mPc = '0;
    tick(); tick();
    rstN = 1'b1;
    tick();
    checkReset();

    for (int n = 0; n < NVEC; n++) runVec(VECS[n], n);

    // R5: kernel mode ignores dispatches
    kv = '{2'd0, 5'd9, 12'h040, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    drive(kv); tick(); usrValid = 1'b0;
    chk(trapPulse == 1'b1, "R4", "trap op9", trapPulse, 1);
    drive(VECS[7]);
    chk(ruleHit == 1'b0, "R5", "no hit in kernel", ruleHit, 0);
    tick(); usrValid = 1'b0;
    chk(trapPulse == 1'b0, "R5", "no trap in kernel", trapPulse, 0);
    chk(kernelMode == 1'b1, "R5", "still kernel", kernelMode, 1);
    kRead(3'd0, rd); chk(rd == 8'd9, "R5", "cell0 untouched", rd, 9);

    // R7: key-field write invalidates until both outputs rewritten
    kWrite(3'd5, 8'h00);
    kWrite(3'd6, 8'h01);
    kWrite(3'd1, 8'h01);
    kWrite(3'd5, 8'h00);
    doReturn(12'h040, "R8");
    kv.pcTag = 8'h01;
    drive(kv);
    chk(ruleHit == 1'b0, "R7", "stale outputs miss", ruleHit, 0);
    tick(); usrValid = 1'b0;
    chk(trapPulse == 1'b1, "R7", "stale trap", trapPulse, 1);
    kWrite(3'd5, 8'h00);
    kWrite(3'd6, 8'h01);
    doReturn(12'h040, "R8");
    drive(kv);
    chk(ruleHit == 1'b1, "R7", "refilled hit", ruleHit, 1);
    chk(rulePcTag == 8'h01, "R7", "refilled pc tag", rulePcTag, 1);
    tick(); usrValid = 1'b0;

    // R6: user-mode writes ignored
    kWrite(3'd5, 8'hAB);
    kRead(3'd5, rd); chk(rd == 8'h00, "R6", "user write ignored", rd, 0);

    // R9: halt on deny
    kv = '{2'd0, 5'd10, 12'h050, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    drive(kv); tick(); usrValid = 1'b0;
    kJump = 1'b1; kJumpAddr = 12'h123; tick(); kJump = 1'b0;
    chk(halted == 1'b0, "R9", "ordinary jump", halted, 0);
    kJump = 1'b1; kJumpAddr = 12'hFFF; tick(); kJump = 1'b0;
    chk(halted == 1'b1, "R9", "halted", halted, 1);
    retStrobe = 1'b1; tick(); retStrobe = 1'b0;
    chk(resumeValid == 1'b0, "R9", "no return", resumeValid, 0);
    chk(kernelMode == 1'b1, "R9", "mode frozen", kernelMode, 1);
    kWrite(3'd5, 8'h77);
    kRead(3'd5, rd); chk(rd == 8'h00, "R9", "write blocked", rd, 0);
    tick();
    chk(halted == 1'b1, "R9", "sticky", halted, 1);

    rstN = 1'b0; tick(); tick(); rstN = 1'b1; tick();
    checkReset();

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end
endmodule